// File: doc/BRIEF.md
# Programmable 24-bit Counter Timer Channel

This block is one 24-bit counter channel that a host reaches through four 16-bit word registers: count/preload low, count/preload high, mode and command. The counter advances either from a quadrature encoder pair (A and B phases), decoded at single, double or quadruple resolution, or from a plain tick input whose direction is chosen by a mode bit. The encoder, tick and index inputs are synchronised inside the block.

Two 24-bit preload registers supply reload values. A terminal count (a down-step taken while the count is zero) reloads the counter and drives a capture/output flag, which appears on the output pin with optional inversion. The host builds an encoder counter with index reload, a one-shot, or a pulse train from these parts. In pulse-train operation preload 0 holds the pulse width and preload 1 holds the period, both in source ticks, with the period greater than the width and the width non-zero. Reading the low word first can freeze a snapshot, so the high word read afterwards belongs to the same count.

Top module: `ctr24_channel`

## Requirements
- R1: While reset is high, and on the cycle after it, the count, both preloads, the mode word and the flag are zero, rd_data is 0 and out_pin is 0.
- R2: A read (rd_en high) returns data on the next cycle with rd_valid high. Select 0 gives count bits 15:0. Select 1 gives count bits 23:16 in bits 7:0 with bits 15:8 zero. Select 2 gives the mode word. Select 3 gives 0.
- R3: A write to select 1 stores wr_data[7:0] as a staged high byte. A following write to select 0 commits {staged byte, wr_data} to preload 1 if mode bit 14 is 1, otherwise to preload 0.
- R4: A write to select 3 is a command. Bit 15 clears the count and the flag and restarts the pulse-train phase. Bit 14 loads the count from preload 0 and restarts the phase; when both are set the count ends at preload 0. Bit 3 clears the flag.
- R5: With mode bit 12 at 0, mode bits 10:9 choose quadrature decoding: 0 counts rising A edges, 1 counts every A edge, 2 counts every A or B edge, and 3 counts nothing. The step is up when A leads B, following the order {A,B} 00, 10, 11, 01.
- R6: An encoder change in which A and B both toggle between two synchronised samples does not move the count.
- R7: With mode bit 12 at 1, each rising edge of tick_in is one step: up when mode bit 11 is 0, down when it is 1.
- R8: When alternating reload is off (mode bit 0 at 0), a down-step at count 0 reloads preload 0 and sets the flag. An up-step at 0xFFFFFF wraps to 0 without touching the flag.
- R9: out_pin equals the flag, inverted when mode bit 1 is 1.
- R10: When mode bits 4:2 equal 4, a rising edge of index_in loads the count from preload 0. With any other value, index_in has no effect.
- R11: When mode bit 13 is 1, a low-word read snapshots the whole count, and later high-word reads return the snapshot's upper byte. When the bit is 0, high-word reads return the live count.
- R12: When mode bit 0 is 1, terminal counts alternate. Entering the gap phase clears the flag and loads preload1 - preload0 - 1. Entering the width phase sets the flag and loads preload0 - 1. The flag is then high for preload 0 steps of every preload 1 steps.
- R13: When mode bits 8:7 equal 2, steps are ignored while the flag is set. Clearing the flag lets counting resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 low, 1 high, 2 mode, 3 command |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | Read source: 0 low, 1 high, 2 mode, 3 zero |
| rd_data | output | 16 | Read data, one cycle after rd_en |
| rd_valid | output | 1 | rd_data holds a read result |
| phase_a | input | 1 | Encoder phase A (asynchronous) |
| phase_b | input | 1 | Encoder phase B (asynchronous) |
| tick_in | input | 1 | Count tick for software-direction mode (asynchronous) |
| index_in | input | 1 | Encoder index pulse (asynchronous) |
| out_pin | output | 1 | Capture/output flag after polarity |

## Verification
The hardest state to reach from the ports is the middle of a pulse train. The phase bit is internal and changes only at terminal counts, so the only evidence is the timing of out_pin edges. The stimulus fills preload 1 through the preload-select bit, restarts the phase with reset and load commands, and then issues counted ticks one at a time, checking out_pin at the exact tick where each phase ends. The gated one-shot and the latched read are reached the same way. Each depends on a count value placed just before a boundary (zero, or a carry out of bit 15), which the bench sets through the preload path rather than by long counting.

// File: rtl/ctr24_pkg.sv
package ctr24_pkg;

    localparam int CNT_W   = 24;
    localparam int BUS_W   = 16;
    localparam int HI_W    = CNT_W - BUS_W;
    localparam int SYNC_N  = 2;
    localparam int N_ASYNC = 4;

    typedef enum logic [1:0] {
        REG_LO   = 2'd0,
        REG_HI   = 2'd1,
        REG_MODE = 2'd2,
        REG_CMD  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        SRC_X1  = 2'd0,
        SRC_X2  = 2'd1,
        SRC_X4  = 2'd2,
        SRC_OFF = 2'd3
    } clk_src_e;

    localparam logic [2:0] TRIG_INDEX   = 3'd4;
    localparam logic [1:0] GATE_BY_FLAG = 2'd2;
    localparam int CMD_RESET_BIT = 15;
    localparam int CMD_LOAD_BIT  = 14;
    localparam int CMD_CLR_BIT   = 3;

    // Mode word, MSB first; bit positions are decoded by the counter logic.
    typedef struct packed {
        logic       rsvd;        // 15
        logic       pre_sel;     // 14
        logic       latch_rd;    // 13
        logic       dir_sw;      // 12
        logic       dir_down;    // 11
        clk_src_e   clk_src;     // 10:9
        logic [1:0] gate_ctl;    // 8:7
        logic [1:0] hw_src;      // 6:5
        logic [2:0] reload_trig; // 4:2
        logic       polarity;    // 1
        logic       alt_reload;  // 0
    } mode_t;

    typedef struct packed {
        logic evt;
        logic up;
    } step_t;

    // prev/cur hold {A,B}; forward order 00 -> 10 -> 11 -> 01.
    function automatic step_t quad_step(logic [1:0] prev, logic [1:0] cur, clk_src_e src);
        step_t s;
        logic  a_chg;
        logic  b_chg;
        a_chg = prev[1] ^ cur[1];
        b_chg = prev[0] ^ cur[0];
        s.up  = cur[1] ^ prev[0];
        case (src)
            SRC_X1:  s.evt = a_chg && !b_chg && cur[1];
            SRC_X2:  s.evt = a_chg && !b_chg;
            SRC_X4:  s.evt = a_chg ^ b_chg;
            default: s.evt = 1'b0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/ctr24_sync.sv
module ctr24_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    logic [STAGES-1:0][W-1:0] stg;

    always_ff @(posedge clk) begin
        if (rst) stg <= '0;
        else     stg <= {stg[STAGES-2:0], d_in};
    end

    assign d_out = stg[STAGES-1];
endmodule

// File: rtl/ctr24_evt_gen.sv
module ctr24_evt_gen
    import ctr24_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     syn_a,
    input  logic     syn_b,
    input  logic     syn_tick,
    input  logic     syn_idx,
    input  clk_src_e clk_src,
    input  logic     dir_sw,
    input  logic     dir_down,
    output step_t    step,
    output logic     idx_rise
);
    logic prev_a, prev_b, prev_tick, prev_idx;
    step_t q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_a    <= 1'b0;
            prev_b    <= 1'b0;
            prev_tick <= 1'b0;
            prev_idx  <= 1'b0;
        end else begin
            prev_a    <= syn_a;
            prev_b    <= syn_b;
            prev_tick <= syn_tick;
            prev_idx  <= syn_idx;
        end
    end

    always_comb begin
        q = quad_step({prev_a, prev_b}, {syn_a, syn_b}, clk_src);
        if (dir_sw) begin
            step.evt = syn_tick && !prev_tick;
            step.up  = !dir_down;
        end else begin
            step = q;
        end
    end

    assign idx_rise = syn_idx && !prev_idx;
endmodule

// File: rtl/ctr24_core.sv
module ctr24_core
    import ctr24_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             alt_reload,
    input  logic [1:0]       gate_ctl,
    input  logic [2:0]       reload_trig,
    input  logic [CNT_W-1:0] pr0,
    input  logic [CNT_W-1:0] pr1,
    input  logic             cmd_wr,
    input  logic             cmd_reset,
    input  logic             cmd_load,
    input  logic             cmd_clr,
    input  step_t            step,
    input  logic             idx_rise,
    output logic [CNT_W-1:0] count,
    output logic             flag
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic seg;
    logic enabled;
    logic [CNT_W-1:0] gap_len;
    logic [CNT_W-1:0] width_len;

    assign enabled   = (gate_ctl != GATE_BY_FLAG) || !flag;
    assign gap_len   = pr1 - pr0 - ONE;
    assign width_len = pr0 - ONE;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            flag  <= 1'b0;
            seg   <= 1'b0;
        end else if (cmd_wr) begin
            if (cmd_reset) begin
                count <= '0;
                flag  <= 1'b0;
                seg   <= 1'b0;
            end
            if (cmd_load) begin
                count <= pr0;
                seg   <= 1'b0;
            end
            if (cmd_clr) flag <= 1'b0;
        end else if (idx_rise && reload_trig == TRIG_INDEX) begin
            count <= pr0;
        end else if (step.evt && enabled) begin
            if (step.up) begin
                count <= count + ONE;
            end else if (count != '0) begin
                count <= count - ONE;
            end else if (alt_reload) begin
                if (!seg) begin
                    seg   <= 1'b1;
                    flag  <= 1'b0;
                    count <= gap_len;
                end else begin
                    seg   <= 1'b0;
                    flag  <= 1'b1;
                    count <= width_len;
                end
            end else begin
                count <= pr0;
                flag  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/ctr24_channel.sv
module ctr24_channel
    import ctr24_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [BUS_W-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [1:0]        rd_sel,
    output logic [BUS_W-1:0]  rd_data,
    output logic              rd_valid,
    input  logic              phase_a,
    input  logic              phase_b,
    input  logic              tick_in,
    input  logic              index_in,
    output logic              out_pin
);
    mode_t             mode;
    logic [HI_W-1:0]   hi_stage;
    logic [CNT_W-1:0]  pr0, pr1, snap, count;
    logic              flag;
    logic [N_ASYNC-1:0] syn;
    step_t             step;
    logic              idx_rise;
    logic              cmd_wr;
    logic [CNT_W-1:0]  hi_src;
    logic [BUS_W-1:0]  rd_next;

    ctr24_sync #(.W(N_ASYNC), .STAGES(SYNC_N)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .d_in  ({index_in, tick_in, phase_b, phase_a}),
        .d_out (syn)
    );

    ctr24_evt_gen evt_i (
        .clk      (clk),
        .rst      (rst),
        .syn_a    (syn[0]),
        .syn_b    (syn[1]),
        .syn_tick (syn[2]),
        .syn_idx  (syn[3]),
        .clk_src  (mode.clk_src),
        .dir_sw   (mode.dir_sw),
        .dir_down (mode.dir_down),
        .step     (step),
        .idx_rise (idx_rise)
    );

    assign cmd_wr = wr_en && (wr_sel == REG_CMD);

    ctr24_core core_i (
        .clk         (clk),
        .rst         (rst),
        .alt_reload  (mode.alt_reload),
        .gate_ctl    (mode.gate_ctl),
        .reload_trig (mode.reload_trig),
        .pr0         (pr0),
        .pr1         (pr1),
        .cmd_wr      (cmd_wr),
        .cmd_reset   (wr_data[CMD_RESET_BIT]),
        .cmd_load    (wr_data[CMD_LOAD_BIT]),
        .cmd_clr     (wr_data[CMD_CLR_BIT]),
        .step        (step),
        .idx_rise    (idx_rise),
        .count       (count),
        .flag        (flag)
    );

    // Register writes: mode word, staged high byte, preload commit.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= '0;
            hi_stage <= '0;
            pr0      <= '0;
            pr1      <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                REG_MODE: mode     <= mode_t'(wr_data);
                REG_HI:   hi_stage <= wr_data[HI_W-1:0];
                REG_LO: begin
                    if (mode.pre_sel) pr1 <= {hi_stage, wr_data};
                    else              pr0 <= {hi_stage, wr_data};
                end
                default: ;
            endcase
        end
    end

    assign hi_src = mode.latch_rd ? snap : count;

    always_comb begin
        case (reg_sel_e'(rd_sel))
            REG_LO:   rd_next = count[BUS_W-1:0];
            REG_HI:   rd_next = {{(BUS_W-HI_W){1'b0}}, hi_src[CNT_W-1:BUS_W]};
            REG_MODE: rd_next = BUS_W'(mode);
            default:  rd_next = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
            snap     <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_next;
            if (rd_en && rd_sel == REG_LO && mode.latch_rd) snap <= count;
        end
    end

    assign out_pin = flag ^ mode.polarity;
endmodule

// File: rtl/ctr24_channel_chk.sv
module ctr24_channel_chk
    import ctr24_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [BUS_W-1:0] wr_data,
    input logic             rd_en,
    input logic [1:0]       rd_sel,
    input logic [BUS_W-1:0] rd_data,
    input logic             rd_valid,
    input logic [BUS_W-1:0] mode_w,
    input logic [HI_W-1:0]  hi_stage,
    input logic [CNT_W-1:0] pr0,
    input logic [CNT_W-1:0] count,
    input logic             flag
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (count == '0 && !flag && rd_data == '0));

    // R2
    rd_valid_tracks_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    // R2
    rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

    // R2
    hi_pad_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == REG_HI) |=> rd_data[BUS_W-1:HI_W] == '0);

    // R3
    pre0_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == REG_LO && !mode_w[14]) |=> pr0 == {$past(hi_stage), $past(wr_data)});

    // R4
    cmd_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == REG_CMD && wr_data[CMD_RESET_BIT] && !wr_data[CMD_LOAD_BIT])
        |=> (count == '0 && !flag));

    // R4
    cmd_load_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == REG_CMD && wr_data[CMD_LOAD_BIT]) |=> count == $past(pr0));

    // R13
    gate_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(wr_en && wr_sel == REG_CMD) && mode_w[8:7] == GATE_BY_FLAG && flag
         && mode_w[4:2] != TRIG_INDEX) |=> $stable(count));
endmodule

bind ctr24_channel ctr24_channel_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_sel   (rd_sel),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .mode_w   (mode),
    .hi_stage (hi_stage),
    .pr0      (pr0),
    .count    (count),
    .flag     (flag)
);

// File: tb/ctr24_channel_tb_top.sv
module ctr24_channel_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'h0;
    logic        rd_en = 1'b0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        phase_a = 1'b0;
    logic        phase_b = 1'b0;
    logic        tick_in = 1'b0;
    logic        index_in = 1'b0;
    logic        out_pin;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    int qpos   = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    ctr24_channel dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .rd_valid(rd_valid),
        .phase_a(phase_a), .phase_b(phase_b), .tick_in(tick_in),
        .index_in(index_in), .out_pin(out_pin)
    );

    // Monitor: compares each read result against the scoreboard queue.
    always @(negedge clk) begin
        if (rd_valid && !rst) begin
            logic [15:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (rd_data !== e) begin
                fails++;
                $display("FAIL %s: rd_data actual %h expected %h", t, rd_data, e);
            end
        end
    end

    task automatic bus_wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] sel, input logic [15:0] e, input string t);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_en = 1'b1; rd_sel = sel;
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic pin_chk(input logic e, input string t);
        @(negedge clk);
        checks++;
        if (out_pin !== e) begin
            fails++;
            $display("FAIL %s: out_pin actual %b expected %b", t, out_pin, e);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    function automatic logic [1:0] gray(input int p);
        case (p & 3)
            0: return 2'b00;
            1: return 2'b10;
            2: return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    task automatic qstep(input bit fwd);
        if (fwd) qpos = qpos + 1; else qpos = qpos + 3;
        {phase_a, phase_b} = gray(qpos);
        settle();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_in = 1'b1;
            repeat (3) @(negedge clk); tick_in = 1'b0;
            settle();
        end
    endtask

    task automatic set_pre(input bit sel1, input logic [15:0] hi, input logic [15:0] lo,
                           input logic [15:0] mode_after);
        bus_wr(2'd2, sel1 ? 16'h4000 : 16'h0000);
        bus_wr(2'd1, hi);
        bus_wr(2'd0, lo);
        bus_wr(2'd2, mode_after);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        pin_chk(1'b0, "R1 out after reset");
        bus_rd(2'd0, 16'h0000, "R1 count low after reset");
        bus_rd(2'd1, 16'h0000, "R1 count high after reset");
        bus_rd(2'd2, 16'h0000, "R1 mode after reset");

        // R2, R3: high byte truncated, preload 0 commit and load
        set_pre(1'b0, 16'hAB12, 16'h3456, 16'h0000);
        bus_wr(2'd3, 16'h4000);
        bus_rd(2'd0, 16'h3456, "R4 load low");
        bus_rd(2'd1, 16'h0012, "R3 R2 high byte only");
        bus_rd(2'd3, 16'h0000, "R2 command reads zero");

        // R3: preload 1 selected, load still takes preload 0
        set_pre(1'b1, 16'h0000, 16'h0777, 16'h0000);
        bus_wr(2'd3, 16'h8000);
        bus_wr(2'd3, 16'h4000);
        bus_rd(2'd0, 16'h3456, "R3 preload1 write leaves preload0");

        // R10: index with trigger 4, then ignored with trigger 0
        bus_wr(2'd2, 16'h0010);
        bus_wr(2'd3, 16'h8000);
        @(negedge clk); index_in = 1'b1; settle(); index_in = 1'b0; settle();
        bus_rd(2'd0, 16'h3456, "R10 index reload");
        bus_wr(2'd2, 16'h0000);
        bus_wr(2'd3, 16'h8000);
        @(negedge clk); index_in = 1'b1; settle(); index_in = 1'b0; settle();
        bus_rd(2'd0, 16'h0000, "R10 index ignored");

        // R5: quadrature x4
        bus_wr(2'd2, 16'h0400);
        bus_wr(2'd3, 16'h8000);
        for (int i = 0; i < 4; i++) qstep(1'b1);
        bus_rd(2'd0, 16'h0004, "R5 x4 forward");
        for (int i = 0; i < 2; i++) qstep(1'b0);
        bus_rd(2'd0, 16'h0002, "R5 x4 reverse");
        // R6: both phases toggling at once
        @(negedge clk); {phase_a, phase_b} = ~{phase_a, phase_b}; settle();
        bus_rd(2'd0, 16'h0002, "R6 illegal jump ignored");
        @(negedge clk); {phase_a, phase_b} = ~{phase_a, phase_b}; settle();
        bus_rd(2'd0, 16'h0002, "R6 illegal jump back ignored");
        // R5: x2, x1, off
        bus_wr(2'd2, 16'h0200);
        bus_wr(2'd3, 16'h8000);
        for (int i = 0; i < 4; i++) qstep(1'b1);
        bus_rd(2'd0, 16'h0002, "R5 x2 forward");
        bus_wr(2'd2, 16'h0000);
        bus_wr(2'd3, 16'h8000);
        for (int i = 0; i < 4; i++) qstep(1'b1);
        bus_rd(2'd0, 16'h0001, "R5 x1 forward");
        bus_wr(2'd2, 16'h0600);
        bus_wr(2'd3, 16'h8000);
        for (int i = 0; i < 4; i++) qstep(1'b1);
        bus_rd(2'd0, 16'h0000, "R5 source off");

        // R7: software direction
        bus_wr(2'd2, 16'h1000);
        bus_wr(2'd3, 16'h8000);
        ticks(5);
        bus_rd(2'd0, 16'h0005, "R7 ticks up");
        bus_wr(2'd2, 16'h1800);
        ticks(2);
        bus_rd(2'd0, 16'h0003, "R7 ticks down");

        // R8, R9: terminal count reload and flag, polarity
        set_pre(1'b0, 16'h0000, 16'h0002, 16'h1800);
        bus_wr(2'd3, 16'h4000);
        ticks(2);
        bus_rd(2'd0, 16'h0000, "R8 at zero");
        pin_chk(1'b0, "R8 no flag before terminal");
        ticks(1);
        bus_rd(2'd0, 16'h0002, "R8 reload at terminal");
        pin_chk(1'b1, "R8 flag set at terminal");
        bus_wr(2'd2, 16'h1802);
        pin_chk(1'b0, "R9 inverted flag");
        bus_wr(2'd3, 16'h0008);
        pin_chk(1'b1, "R4 R9 clear flag inverted");
        bus_wr(2'd2, 16'h1800);
        pin_chk(1'b0, "R4 flag cleared");
        bus_wr(2'd3, 16'hC000);
        bus_rd(2'd0, 16'h0002, "R4 reset plus load");

        // R8: up wrap leaves flag alone
        set_pre(1'b0, 16'h00FF, 16'hFFFF, 16'h1000);
        bus_wr(2'd3, 16'h4000);
        ticks(1);
        bus_rd(2'd0, 16'h0000, "R8 wrap low");
        bus_rd(2'd1, 16'h0000, "R8 wrap high");
        pin_chk(1'b0, "R8 wrap no flag");

        // R11: latched read across a carry into bit 16
        set_pre(1'b0, 16'h0000, 16'hFFFF, 16'h3000);
        bus_wr(2'd3, 16'h4000);
        bus_rd(2'd0, 16'hFFFF, "R11 low snapshot");
        ticks(1);
        bus_rd(2'd1, 16'h0000, "R11 high from snapshot");
        bus_wr(2'd2, 16'h1000);
        bus_rd(2'd1, 16'h0001, "R11 high live");

        // R12: pulse train, width 2, period 5
        set_pre(1'b0, 16'h0000, 16'h0002, 16'h0000);
        set_pre(1'b1, 16'h0000, 16'h0005, 16'h1801);
        bus_wr(2'd3, 16'h8000);
        bus_wr(2'd3, 16'h4000);
        ticks(6);
        pin_chk(1'b1, "R12 width phase starts");
        ticks(1);
        pin_chk(1'b1, "R12 width phase holds");
        ticks(1);
        pin_chk(1'b0, "R12 gap phase after width");
        ticks(2);
        pin_chk(1'b0, "R12 gap phase holds");
        ticks(1);
        pin_chk(1'b1, "R12 next width after period");

        // R13: gated one-shot
        set_pre(1'b0, 16'h0000, 16'h0001, 16'h1900);
        bus_wr(2'd3, 16'h8000);
        bus_wr(2'd3, 16'h4000);
        ticks(2);
        pin_chk(1'b1, "R13 one-shot fired");
        ticks(3);
        bus_rd(2'd0, 16'h0001, "R13 held while flag set");
        bus_wr(2'd3, 16'h0008);
        ticks(1);
        bus_rd(2'd0, 16'h0000, "R13 resumes after clear");
        bus_rd(2'd2, 16'h1900, "R2 mode readback");

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R2: pending reads actual %0d expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule